// File: doc/BRIEF.md
# Dual-Processor Doorbell Mailbox Unit

This block passes notifications between an application processor and a remote system-control processor. It has two independent channels. Each channel has two links. The transmit link carries doorbells from the application to the remote side, and the receive link carries them back. Every link holds 31 doorbell bits, one flag each. The block carries no message data.

The application side reaches the block through a simple word-addressed register port with a one-cycle read latency. To notify the remote side, it writes ones into a transmit window. It then polls transmit status until the remote side acknowledges. Each channel drives a level interrupt that stays high while any of its receive doorbells is pending, and software services those doorbells through the receive window. The remote side uses a flat mirrored port, one bit per global doorbell, to raise receive doorbells, acknowledge transmit doorbells and see which transmit doorbells are pending.

Top module: `dbell_mbox`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending bit is cleared, `irq` is 0 and `a_rdata` is 0.
- R2: Doorbell n of channel c is global bit c*31+n on `r_raise`, `r_ack` and `r_tx_pend`, so channel 0 uses bits 0 to 30 and channel 1 uses bits 31 to 61.
- R3: A write to a channel's transmit base (offset +0x0) sets transmit doorbell n for every data bit n in 30:0 that is 1. Zero bits and data bit 31 have no effect.
- R4: A read of transmit base +0x4 returns that channel's pending transmit doorbells in bits 30:0. A bit clears on the edge after `r_ack` pulses that global bit.
- R5: `irq[c]` is 1 exactly while any receive doorbell of channel c is pending. `r_raise` sets the bit on the next edge.
- R6: A write to receive base +0xC clears receive doorbell n for every data bit n in 30:0 that is 1. Zero bits have no effect.
- R7: A read of receive base +0x8 returns the channel's pending receive doorbells in bits 30:0, with bit 31 read as 0. Several bits may be pending at once.
- R8: When a set and a clear of the same doorbell happen in the same cycle, the doorbell ends up set. This holds for an application SET against `r_ack`, and for `r_raise` against an application clear.
- R9: Every other address, including misaligned ones, the SET and CLR offsets when read, and the status offsets when written, reads as 0 and has no effect when written.
- R10: Channel 0's transmit base is 0x4000 and channel 1's is 0x0000. Each receive base is its transmit base plus 0x40.
- R11: `a_rdata` holds the read value in the cycle after a read request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Application access request, one cycle per access |
| a_we | input | 1 | 1 = write, 0 = read |
| a_addr | input | 15 | Byte address within the 0x8000 region |
| a_wdata | input | 32 | Write data |
| a_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 2 | Per-channel receive interrupt, level |
| r_raise | input | 62 | Remote raises receive doorbells (global index) |
| r_ack | input | 62 | Remote acknowledges transmit doorbells (global index) |
| r_tx_pend | output | 62 | Pending transmit doorbells seen by the remote side |

## Verification
The assertions assume that every input is a known value after reset. They also assume that `a_we` matters only when `a_req` is high, and that the remote pulses and the application access for a cycle are all sampled on the same edge. The bench drives every input at the falling edge and returns all of them to zero after each step. Random steps mix application reads and writes at defined and undefined addresses with sparse remote raise and acknowledge vectors. Directed steps pin down set-over-clear collisions, writes to bit 31 and reset in the middle of a run.

// File: rtl/dbell_mbox.sv
module dbell_mbox #(
  parameter int NCH    = 2,
  parameter int NDB    = 31,
  parameter int AW     = 15,
  parameter int DW     = 32,
  parameter int STRIDE = 'h4000,
  parameter int RXOFF  = 'h40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_req,
  input  logic                a_we,
  input  logic [AW-1:0]       a_addr,
  input  logic [DW-1:0]       a_wdata,
  output logic [DW-1:0]       a_rdata,
  output logic [NCH-1:0]      irq,
  input  logic [NCH*NDB-1:0]  r_raise,
  input  logic [NCH*NDB-1:0]  r_ack,
  output logic [NCH*NDB-1:0]  r_tx_pend
);
  localparam int NB = NCH * NDB;

  logic [NB-1:0] tx_q, rx_q, set_v, clr_v;
  logic [DW-1:0] rd_ch [NCH];
  logic [DW-1:0] rd_v;
  wire wr = a_req & a_we;
  wire rd = a_req & ~a_we;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int TXB = (NCH - 1 - c) * STRIDE;
    localparam int RXB = TXB + RXOFF;
    wire [NDB-1:0] txs = tx_q[c*NDB +: NDB];
    wire [NDB-1:0] rxs = rx_q[c*NDB +: NDB];

    assign set_v[c*NDB +: NDB] = (wr && a_addr == AW'(TXB))      ? a_wdata[NDB-1:0] : '0;
    assign clr_v[c*NDB +: NDB] = (wr && a_addr == AW'(RXB + 12)) ? a_wdata[NDB-1:0] : '0;
    assign irq[c] = |rxs;
    assign rd_ch[c] = (a_addr == AW'(TXB + 4)) ? DW'(txs) :
                      (a_addr == AW'(RXB + 8)) ? DW'(rxs) : '0;
  end

  always_comb begin
    rd_v = '0;
    for (int c = 0; c < NCH; c++) rd_v = rd_v | rd_ch[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      a_rdata <= '0;
    end else begin
      tx_q    <= (tx_q & ~r_ack) | set_v;
      rx_q    <= (rx_q & ~clr_v) | r_raise;
      a_rdata <= rd ? rd_v : '0;
    end
  end

  assign r_tx_pend = tx_q;
endmodule

// File: rtl/dbell_mbox_chk.sv
module dbell_mbox_chk #(
  parameter int NCH = 2,
  parameter int NDB = 31,
  parameter int AW  = 15,
  parameter int DW  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               a_req,
  input logic               a_we,
  input logic [AW-1:0]      a_addr,
  input logic [DW-1:0]      a_wdata,
  input logic [DW-1:0]      a_rdata,
  input logic [NCH-1:0]     irq,
  input logic [NCH*NDB-1:0] r_raise,
  input logic [NCH*NDB-1:0] r_ack,
  input logic [NCH*NDB-1:0] r_tx_pend
);
  wire wr = a_req & a_we;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && r_ack == '0) |=> $stable(r_tx_pend)); // R3

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((r_tx_pend & $past(r_ack)) == '0)); // R4

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_req && !a_we) |=> a_rdata == '0); // R11

  AST_RDATA_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    a_rdata[DW-1:NDB] == '0); // R7

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_RAISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (r_raise[c*NDB +: NDB] != '0) |=> irq[c]); // R5 R8

    AST_IRQ_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[c]) |-> $past(wr)); // R6
  end
endmodule

bind dbell_mbox dbell_mbox_chk #(.NCH(NCH), .NDB(NDB), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_we(a_we), .a_addr(a_addr),
  .a_wdata(a_wdata), .a_rdata(a_rdata), .irq(irq), .r_raise(r_raise),
  .r_ack(r_ack), .r_tx_pend(r_tx_pend)
);

// File: tb/sim_dbell_mbox.sv
`timescale 1ns/1ps
module sim_dbell_mbox;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        a_req = 0, a_we = 0;
  logic [14:0] a_addr = '0;
  logic [31:0] a_wdata = '0;
  logic [31:0] a_rdata;
  logic [1:0]  irq;
  logic [61:0] r_raise = '0, r_ack = '0;
  logic [61:0] r_tx_pend;

  logic [61:0] tx_m = '0, rx_m = '0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dbell_mbox u0 (.clk(clk), .rst_n(rst_n), .a_req(a_req), .a_we(a_we), .a_addr(a_addr),
                 .a_wdata(a_wdata), .a_rdata(a_rdata), .irq(irq), .r_raise(r_raise),
                 .r_ack(r_ack), .r_tx_pend(r_tx_pend));

  function automatic logic [14:0] txb(int c);
    return 15'((1 - c) * 'h4000);
  endfunction

  function automatic logic [31:0] model_rd(logic [14:0] ad);
    for (int c = 0; c < 2; c++) begin
      if (ad == txb(c) + 15'h4)  return {1'b0, tx_m[c*31 +: 31]};
      if (ad == txb(c) + 15'h48) return {1'b0, rx_m[c*31 +: 31]};
    end
    return '0;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic req, logic we, logic [14:0] ad, logic [31:0] wd,
                      logic [61:0] rs, logic [61:0] ak, string tag);
    logic [31:0] exp_rd;
    exp_rd = (req && !we) ? model_rd(ad) : '0;
    a_req = req; a_we = we; a_addr = ad; a_wdata = wd; r_raise = rs; r_ack = ak;
    for (int c = 0; c < 2; c++) begin
      logic [30:0] s, k;
      s = (req && we && ad == txb(c)) ? wd[30:0] : '0;
      k = (req && we && ad == txb(c) + 15'h4C) ? wd[30:0] : '0;
      tx_m[c*31 +: 31] = (tx_m[c*31 +: 31] & ~ak[c*31 +: 31]) | s;
      rx_m[c*31 +: 31] = (rx_m[c*31 +: 31] & ~k) | rs[c*31 +: 31];
    end
    @(posedge clk); @(negedge clk);
    a_req = 0; a_we = 0; a_addr = '0; a_wdata = '0; r_raise = '0; r_ack = '0;
    chk(tag, "rdata", 64'(a_rdata), 64'(exp_rd));
    chk(tag, "irq", 64'(irq), 64'({|rx_m[61:31], |rx_m[30:0]}));
    chk(tag, "tx_pend", 64'(r_tx_pend), 64'(tx_m));
  endtask

  task automatic wr(logic [14:0] ad, logic [31:0] d, string tag);
    step(1, 1, ad, d, '0, '0, tag);
  endtask
  task automatic rd(logic [14:0] ad, string tag);
    step(1, 0, ad, '0, '0, '0, tag);
  endtask

  task automatic do_reset(string tag);
    rst_n = 0; tx_m = '0; rx_m = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(tag, "irq", 64'(irq), 0);
    chk(tag, "tx_pend", 64'(r_tx_pend), 0);
    chk(tag, "rdata", 64'(a_rdata), 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset("R1 initial reset");

    // R2 R10: global index mapping and window placement
    step(0, 0, '0, '0, 62'(1) << 31, '0, "R2 raise ch1 bit0");
    rd(15'h0048, "R10 R7 ch1 rx status");
    step(0, 0, '0, '0, 62'(1) << 30, '0, "R2 raise ch0 bit30");
    rd(15'h4048, "R10 R7 ch0 rx status");
    // R3: bit 31 ignored, zero bits leave state
    wr(15'h4000, 32'h8000_0005, "R3 set with bit31");
    rd(15'h4004, "R4 tx status ch0");
    wr(15'h4000, 32'h0000_0002, "R3 zero bits no effect");
    wr(15'h0000, 32'h4000_0001, "R3 ch1 set");
    rd(15'h0004, "R10 R4 ch1 tx status");
    // R4: remote acknowledge
    step(0, 0, '0, '0, '0, 62'(1), "R4 ack ch0 bit0");
    rd(15'h4004, "R4 tx status after ack");
    // R8: set and clear in the same cycle
    step(1, 1, 15'h4000, 32'h2, '0, 62'(2), "R8 set vs ack");
    step(1, 1, 15'h004C, 32'h1, 62'(1) << 31, '0, "R8 raise vs clr");
    rd(15'h0048, "R8 rx kept");
    // R6: clear and interrupt drop
    wr(15'h004C, 32'h1, "R6 clr ch1 bit0");
    wr(15'h404C, 32'h0, "R6 zero clr");
    wr(15'h404C, 32'h4000_0000, "R6 R5 clr ch0 bit30");
    // R9: undefined offsets
    step(0, 0, '0, '0, 62'h3 | (62'h3 << 31), '0, "R5 raise several");
    wr(15'h4008, 32'hFFFF_FFFF, "R9 write rx stat offset in tx window");
    wr(15'h4044, 32'hFFFF_FFFF, "R9 write rx+4");
    wr(15'h0008, 32'hFFFF_FFFF, "R9 write tx+8");
    wr(15'h0048, 32'hFFFF_FFFF, "R9 write rx status");
    wr(15'h4001, 32'hFFFF_FFFF, "R9 misaligned set");
    wr(15'h2000, 32'hFFFF_FFFF, "R9 gap write");
    rd(15'h4000, "R9 read set offset");
    rd(15'h404C, "R9 read clr offset");
    rd(15'h7FFC, "R9 read top");
    rd(15'h0048, "R7 multiple pending");
    rd(15'h4048, "R7 multiple pending ch0");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int c, k;
      logic [14:0] ad;
      logic [61:0] rs, ak;
      c = int'($urandom % 2);
      k = int'($urandom % 8);
      case (k)
        0, 1: ad = txb(c);
        2: ad = txb(c) + 15'h4;
        3: ad = txb(c) + 15'h48;
        4, 5: ad = txb(c) + 15'h4C;
        6: ad = txb(c) + 15'(4 * ($urandom % 20));
        default: ad = 15'($urandom);
      endcase
      rs = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      ak = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom % 3 == 0) rs = '0;
      step($urandom % 4 != 0, $urandom % 2 == 0, ad, $urandom, rs, ak,
           "R2 R3 R4 R5 R6 R7 R8 R9 R11 random");
      if (i == 1500) do_reset("R1 mid-run reset");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule